// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block performs the architectural state update of a 32-bit hart at the moment it takes a trap. A one-cycle strobe brings in the trap: an interrupt flag, a cause number, the faulting address and the pc of the trapping instruction. In that same cycle the unit decides whether supervisor or machine mode handles the trap. It then writes that mode's cause, exception-pc and trap-value registers, updates the interrupt-enable stack in the status bits and switches privilege. On the following cycle it presents the handler address on a redirect output.

The vector bases and the two delegation masks come in from the surrounding CSR file. A small load port restores the privilege and the two global enable bits. Trap return logic drives this port after an exception return, and the bench uses it to place the hart in any starting state. Privilege is encoded U=0, S=1, M=3.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the privilege is M (3), every cause, epc and tval register is zero, all status bits are zero and `redirect_o` is low.
- R2: An interrupt records a cause of bit 31 set, with the interrupt number in the low bits. An exception records its code with bit 31 clear.
- R3: An exception with code 8 (environment call) is recorded as 8 from U, 9 from S and 11 from M.
- R4: Interrupts look up their number in `mideleg_i`, and exceptions look up their code in `medeleg_i`. The other mask has no effect.
- R5: A trap goes to S only when the current privilege is U or S and the selected delegation bit is 1. From M it always goes to M.
- R6: On S entry: scause, sepc (old pc) and stval are written, spie takes sie, spp takes the old privilege bit 0, sie clears and the privilege becomes S (1). The machine registers and machine status bits keep their values.
- R7: On M entry: mcause, mepc (old pc) and mtval are written, mpie takes mie, mpp takes the old privilege, mie clears and the privilege becomes M (3). The supervisor registers and supervisor status bits keep their values.
- R8: The target mode's tval takes `trap_addr_i` for exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For every other exception and for every interrupt it is cleared.
- R9: The load port sets the privilege, mie and sie. A loaded privilege of 2 becomes U (0). When a trap and a load arrive in the same cycle, the trap takes effect and the load is dropped.
- R10: One cycle after a trap strobe, `redirect_o` is high for exactly one cycle. `redirect_pc_o` then holds the target mode's vector base, used as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Trap strobe, one cycle per trap |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_code_i | input | 5 | Interrupt number or exception code |
| trap_addr_i | input | 32 | Faulting address |
| pc_i | input | 32 | pc of the trapping instruction |
| mtvec_i | input | 32 | Machine handler base |
| stvec_i | input | 32 | Supervisor handler base |
| medeleg_i | input | 32 | Exception delegation mask |
| mideleg_i | input | 32 | Interrupt delegation mask |
| ld_i | input | 1 | Load privilege and enables |
| ld_priv_i | input | 2 | Privilege to load |
| ld_mie_i | input | 1 | Machine enable to load |
| ld_sie_i | input | 1 | Supervisor enable to load |
| priv_o | output | 2 | Current privilege |
| redirect_o | output | 1 | Handler redirect valid |
| redirect_pc_o | output | 32 | Handler address |
| mcause_o | output | 32 | Machine cause |
| mepc_o | output | 32 | Machine exception pc |
| mtval_o | output | 32 | Machine trap value |
| scause_o | output | 32 | Supervisor cause |
| sepc_o | output | 32 | Supervisor exception pc |
| stval_o | output | 32 | Supervisor trap value |
| mie_o | output | 1 | Machine global enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| sie_o | output | 1 | Supervisor global enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |

## Verification
The assertions assume that `trap_i` arrives only as a clean strobe with its companion fields stable in the same cycle. They also assume that the load port never injects a privilege outside U, S, M other than the reserved value 2, which the block folds to U. The stimulus drives every field together at the falling edge and lowers the strobe before the next trap. It loads the privilege only with 0, 1, 2 or 3. For each trap it sets the unused delegation mask to the complement of the one in use, so a swapped lookup shows up as a wrong target mode.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRIV_U   = 2'd0;
  localparam logic [1:0] PRIV_S   = 2'd1;
  localparam logic [1:0] PRIV_RSV = 2'd2;
  localparam logic [1:0] PRIV_M   = 2'd3;

  localparam int unsigned CODE_ECALL_U = 8;

  // exception codes that carry a faulting address
  function automatic logic code_has_addr(input int unsigned code);
    case (code)
      0, 1, 4, 5, 6, 7, 12, 13, 15: code_has_addr = 1'b1;
      default:                      code_has_addr = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix import trap_pkg::*; #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 5
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  output logic [CODE_W-1:0] code_o,
  output logic [XLEN-1:0]   cause_o,
  output logic              has_addr_o
);
  localparam int unsigned PAD_W = XLEN - 1 - CODE_W;

  always_comb begin
    code_o = code_i;
    if (!irq_i && code_i == CODE_W'(CODE_ECALL_U))
      code_o = CODE_W'(CODE_ECALL_U) | CODE_W'(priv_i);
    cause_o    = {irq_i, {PAD_W{1'b0}}, code_o};
    has_addr_o = !irq_i && code_has_addr(int'(code_o));
  end
endmodule

// File: rtl/trap_route.sv
module trap_route import trap_pkg::*; #(
  parameter int unsigned CODE_W  = 5,
  localparam int unsigned DELEG_W = 1 << CODE_W
) (
  input  logic               irq_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [1:0]         priv_i,
  input  logic [DELEG_W-1:0] medeleg_i,
  input  logic [DELEG_W-1:0] mideleg_i,
  output logic               to_s_o
);
  logic sel_bit;
  assign sel_bit = irq_i ? mideleg_i[code_i] : medeleg_i[code_i];
  assign to_s_o  = (priv_i != PRIV_M) && sel_bit;
endmodule

// File: rtl/trap_mode_bank.sv
module trap_mode_bank #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] tval_i,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] tval_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
      epc_o   <= '0;
      tval_o  <= '0;
    end else if (we_i) begin
      cause_o <= cause_i;
      epc_o   <= epc_i;
      tval_o  <= tval_i;
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit import trap_pkg::*; #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CODE_W  = 5,
  localparam int unsigned DELEG_W = 1 << CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic               trap_irq_i,
  input  logic [CODE_W-1:0]  trap_code_i,
  input  logic [XLEN-1:0]    trap_addr_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    mtvec_i,
  input  logic [XLEN-1:0]    stvec_i,
  input  logic [DELEG_W-1:0] medeleg_i,
  input  logic [DELEG_W-1:0] mideleg_i,
  input  logic               ld_i,
  input  logic [1:0]         ld_priv_i,
  input  logic               ld_mie_i,
  input  logic               ld_sie_i,
  output logic [1:0]         priv_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    mcause_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [XLEN-1:0]    mtval_o,
  output logic [XLEN-1:0]    scause_o,
  output logic [XLEN-1:0]    sepc_o,
  output logic [XLEN-1:0]    stval_o,
  output logic               mie_o,
  output logic               mpie_o,
  output logic [1:0]         mpp_o,
  output logic               sie_o,
  output logic               spie_o,
  output logic               spp_o
);
  localparam int unsigned NMODE = 2; // 0: S bank, 1: M bank

  logic [1:0]        priv_q;
  logic              mie_q, mpie_q, sie_q, spie_q, spp_q;
  logic [1:0]        mpp_q;
  logic              redir_q;
  logic [XLEN-1:0]   redir_pc_q;

  logic [CODE_W-1:0] code_eff;
  logic [XLEN-1:0]   cause_full;
  logic              has_addr;
  logic              to_s;
  logic [XLEN-1:0]   tval_d;

  trap_cause_fix #(.XLEN(XLEN), .CODE_W(CODE_W)) u_fix (
    .irq_i      (trap_irq_i),
    .code_i     (trap_code_i),
    .priv_i     (priv_q),
    .code_o     (code_eff),
    .cause_o    (cause_full),
    .has_addr_o (has_addr)
  );

  trap_route #(.CODE_W(CODE_W)) u_route (
    .irq_i     (trap_irq_i),
    .code_i    (code_eff),
    .priv_i    (priv_q),
    .medeleg_i (medeleg_i),
    .mideleg_i (mideleg_i),
    .to_s_o    (to_s)
  );

  assign tval_d = has_addr ? trap_addr_i : '0;

  logic [XLEN-1:0] bank_cause [NMODE];
  logic [XLEN-1:0] bank_epc   [NMODE];
  logic [XLEN-1:0] bank_tval  [NMODE];

  for (genvar g = 0; g < NMODE; g++) begin : g_bank
    logic sel;
    assign sel = (g == 0) ? to_s : !to_s;
    trap_mode_bank #(.XLEN(XLEN)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (trap_i && sel),
      .cause_i (cause_full),
      .epc_i   (pc_i),
      .tval_i  (tval_d),
      .cause_o (bank_cause[g]),
      .epc_o   (bank_epc[g]),
      .tval_o  (bank_tval[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q     <= PRIV_M;
      mie_q      <= 1'b0;
      mpie_q     <= 1'b0;
      mpp_q      <= PRIV_U;
      sie_q      <= 1'b0;
      spie_q     <= 1'b0;
      spp_q      <= 1'b0;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      redir_q <= trap_i;
      if (trap_i) begin
        if (to_s) begin
          spie_q     <= sie_q;
          spp_q      <= priv_q[0];
          sie_q      <= 1'b0;
          priv_q     <= PRIV_S;
          redir_pc_q <= stvec_i;
        end else begin
          mpie_q     <= mie_q;
          mpp_q      <= priv_q;
          mie_q      <= 1'b0;
          priv_q     <= PRIV_M;
          redir_pc_q <= mtvec_i;
        end
      end else if (ld_i) begin
        priv_q <= (ld_priv_i == PRIV_RSV) ? PRIV_U : ld_priv_i;
        mie_q  <= ld_mie_i;
        sie_q  <= ld_sie_i;
      end
    end
  end

  assign priv_o        = priv_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = redir_pc_q;
  assign scause_o      = bank_cause[0];
  assign sepc_o        = bank_epc[0];
  assign stval_o       = bank_tval[0];
  assign mcause_o      = bank_cause[1];
  assign mepc_o        = bank_epc[1];
  assign mtval_o       = bank_tval[1];
  assign mie_o         = mie_q;
  assign mpie_o        = mpie_q;
  assign mpp_o         = mpp_q;
  assign sie_o         = sie_q;
  assign spie_o        = spie_q;
  assign spp_o         = spp_q;

  p_priv_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_q != PRIV_RSV);

  p_route_from_m_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && priv_q == PRIV_M) |-> !to_s);

  p_s_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && to_s) |=> (priv_q == PRIV_S && !sie_q && sepc_o == $past(pc_i)
                          && $stable(mepc_o)));

  p_m_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && !to_s) |=> (priv_q == PRIV_M && !mie_q && mepc_o == $past(pc_i)
                           && $stable(sepc_o)));

  p_irq_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && trap_irq_i && !to_s) |=> mcause_o[XLEN-1]);

  p_redirect_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> redirect_o);

  p_redirect_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_i |=> !redirect_o);
endmodule

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MTVEC = 32'h8000_0100;
  localparam logic [31:0] STVEC = 32'h8000_0200;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trap_i = 1'b0, trap_irq_i = 1'b0;
  logic [4:0]  trap_code_i = '0;
  logic [31:0] trap_addr_i = '0, pc_i = '0;
  logic [31:0] medeleg_i = '0, mideleg_i = '0;
  logic        ld_i = 1'b0, ld_mie_i = 1'b0, ld_sie_i = 1'b0;
  logic [1:0]  ld_priv_i = '0;
  logic [1:0]  priv_o, mpp_o;
  logic        redirect_o, mie_o, mpie_o, sie_o, spie_o, spp_o;
  logic [31:0] redirect_pc_o, mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .trap_i(trap_i), .trap_irq_i(trap_irq_i),
    .trap_code_i(trap_code_i), .trap_addr_i(trap_addr_i), .pc_i(pc_i),
    .mtvec_i(MTVEC), .stvec_i(STVEC), .medeleg_i(medeleg_i), .mideleg_i(mideleg_i),
    .ld_i(ld_i), .ld_priv_i(ld_priv_i), .ld_mie_i(ld_mie_i), .ld_sie_i(ld_sie_i),
    .priv_o(priv_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .mcause_o(mcause_o), .mepc_o(mepc_o), .mtval_o(mtval_o),
    .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o),
    .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
    .sie_o(sie_o), .spie_o(spie_o), .spp_o(spp_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench shadow of architectural state
  logic [31:0] e_mcause = 0, e_mepc = 0, e_mtval = 0, e_scause = 0, e_sepc = 0, e_stval = 0;
  logic        e_mpie = 0, e_spie = 0, e_spp = 0;
  logic [1:0]  e_mpp = 0;

  function automatic logic addr_cause(input int c);
    return (c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 7 ||
            c == 12 || c == 13 || c == 15);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int iter = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "priv", 32'(priv_o), 32'd3);
    chk("R1", "mcause", mcause_o, 0);
    chk("R1", "mepc", mepc_o, 0);
    chk("R1", "mtval", mtval_o, 0);
    chk("R1", "scause", scause_o, 0);
    chk("R1", "sepc", sepc_o, 0);
    chk("R1", "stval", stval_o, 0);
    chk("R1", "status", {mie_o, mpie_o, mpp_o, sie_o, spie_o, spp_o}, 0);
    chk("R1", "redirect", 32'(redirect_o), 0);

    // R9 reserved privilege folds to U
    ld_i = 1; ld_priv_i = 2'd2; ld_mie_i = 1; ld_sie_i = 1;
    @(negedge clk);
    ld_i = 0;
    chk("R9", "priv after load 2", 32'(priv_o), 0);
    chk("R9", "mie/sie loaded", {mie_o, sie_o}, 2'b11);

    for (int pi = 0; pi < 3; pi++) begin
      for (int irq = 0; irq < 2; irq++) begin
        for (int c = 0; c < 32; c++) begin
          for (int m = 0; m < 2; m++) begin
            logic [1:0]  p;
            logic        mi, si, to_s;
            logic [31:0] mask, cause, tv;
            p  = (pi == 2) ? 2'd3 : 2'(pi);
            mi = iter[0];
            si = iter[1];
            // load starting state
            ld_i = 1; ld_priv_i = p; ld_mie_i = mi; ld_sie_i = si;
            @(negedge clk);
            ld_i = 0;
            chk("R9", "loaded priv", 32'(priv_o), 32'(p));
            // the ecall code is rewritten before the lookup
            begin
              int ce;
              ce = (irq == 0 && c == 8) ? 8 + int'(p) : c;
              mask = (m == 0) ? (32'd1 << ce) : ~(32'd1 << ce);
              cause = (irq == 1) ? (32'h8000_0000 | 32'(c)) : 32'(ce);
              tv = (irq == 0 && addr_cause(ce)) ? 32'hA5A0_0000 + 32'(iter) : 0;
            end
            // R4: the unused mask is the complement of the used one
            if (irq == 1) begin mideleg_i = mask; medeleg_i = ~mask; end
            else          begin medeleg_i = mask; mideleg_i = ~mask; end
            to_s = (p != 2'd3) && (m == 0);
            trap_i = 1; trap_irq_i = irq[0]; trap_code_i = 5'(c);
            trap_addr_i = 32'hA5A0_0000 + 32'(iter);
            pc_i = 32'h0000_1000 + 32'(iter * 4);
            @(negedge clk);
            trap_i = 0;
            if (to_s) begin
              e_scause = cause; e_sepc = 32'h0000_1000 + 32'(iter * 4); e_stval = tv;
              e_spie = si; e_spp = p[0];
            end else begin
              e_mcause = cause; e_mepc = 32'h0000_1000 + 32'(iter * 4); e_mtval = tv;
              e_mpie = mi; e_mpp = p;
            end
            chk("R5", "priv after trap", 32'(priv_o), to_s ? 32'd1 : 32'd3);
            chk("R2", "mcause", mcause_o, e_mcause);
            chk("R3", "scause", scause_o, e_scause);
            chk("R6", "sepc", sepc_o, e_sepc);
            chk("R7", "mepc", mepc_o, e_mepc);
            chk("R8", "mtval", mtval_o, e_mtval);
            chk("R8", "stval", stval_o, e_stval);
            chk("R6", "s status", {sie_o, spie_o, spp_o},
                {(to_s ? 1'b0 : si), e_spie, e_spp});
            chk("R7", "m status", {mie_o, mpie_o, mpp_o},
                {(to_s ? mi : 1'b0), e_mpie, e_mpp});
            chk("R10", "redirect", 32'(redirect_o), 1);
            chk("R10", "redirect pc", redirect_pc_o, to_s ? STVEC : MTVEC);
            chk("R4", "route", 32'(priv_o == 2'd1), 32'(to_s));
            @(negedge clk);
            chk("R10", "redirect drops", 32'(redirect_o), 0);
            iter++;
          end
        end
      end
    end

    // R9 trap wins over simultaneous load
    ld_i = 1; ld_priv_i = 2'd0; ld_mie_i = 1; ld_sie_i = 1;
    @(negedge clk);
    medeleg_i = '0; mideleg_i = '0;
    ld_priv_i = 2'd1; ld_mie_i = 1; ld_sie_i = 1;
    trap_i = 1; trap_irq_i = 0; trap_code_i = 5'd2; pc_i = 32'h0000_4444;
    @(negedge clk);
    ld_i = 0; trap_i = 0;
    chk("R9", "trap over load priv", 32'(priv_o), 32'd3);
    chk("R9", "trap over load mie", 32'(mie_o), 0);
    chk("R9", "trap over load mpp", 32'(mpp_o), 0);
    chk("R8", "illegal-instr tval", mtval_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule